// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block decodes the write side of a NOR-style parallel flash that follows the common unlock-cycle command set. Bus writes arrive as single-cycle strobes carrying a byte address and a data word. The sequencer steps through the unlock pair, the command cycle, program, erase and the query modes, and keeps the flash contents in an on-chip word array. Programming can only clear bits, because the new data is ANDed into the stored word. An erase sets every word of a sector, or of the whole chip, to all ones.

The block also reports which source should answer a read: the array, the identification codes, the status register or the query table. That answer is given as a 2-bit mode. A registered read port returns the stored word one cycle after the address is presented. An unlock-bypass mode lets a host issue a stream of commands without repeating the unlock pair before each one. Erase timing belongs to an external status unit. The sequencer sends that unit a one-cycle start pulse tagged with the erase kind and sector, and it waits for a one-cycle done pulse in return.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the mode output is array (0) and erase_start is low. rd_data shows the word at rd_addr one clock after the address is applied.
- R2: A command is accepted only after 0xAA at word offset UNLOCK0 and then 0x55 at word offset UNLOCK1. It must then sit at UNLOCK0 and be one of 0x20, 0x80, 0x90 or 0xA0. A wrong address, wrong data or unknown opcode at any step returns to read mode, and the unlock pair must then be given again.
- R3: Command 0x90 selects the ID mode (1). From there, 0x98 at word offset 0x55 selects query mode (3), and any other write returns to read mode. When bypass is active, a write of 0x00 in ID mode returns to read mode with bypass cleared.
- R4: In read mode, 0x98 at word offset 0x55 selects query mode (3) directly. Any write in query mode returns to read mode.
- R5: Command 0xA0 selects status mode (2). The next write ANDs its data into the addressed word, so bits are never set. The sequencer then returns to read mode, or to the command cycle if bypass is active.
- R6: A write whose low byte is 0xF0 returns to read mode and clears bypass from any state except two. While waiting for program data, 0xF0 is stored as data. While an erase is busy, 0xF0 is ignored (see R10).
- R7: Command 0x20 enters bypass. In bypass, the command cycle needs no unlock pair and no address match, and the sequencer returns to that command cycle after each program.
- R8: Command 0x80 followed by a second unlock pair and 0x30 at any address erases the sector that holds that address. If the final write is instead 0x10 at UNLOCK0, the whole chip is erased. Erased words read 0xFF and other sectors are untouched. erase_start pulses for exactly one cycle with erase_kind (1 = chip, 0 = sector) and erase_sector. The mode is status (2) while the erase is busy.
- R9: An erase ends only when the internal fill has completed and erase_done has been seen, in either order. The sequencer then returns to read mode, or to the command cycle when bypass is active.
- R10: Every write during a busy erase is ignored, including 0xF0.
- R11: Command addresses are compared as the offset within a sector, shifted right by log2 of the device width in bytes. The unlock pair therefore matches in any sector. Commands are decoded from the low data byte.
- R12: In the erase command cycle, 0x10 at an address other than UNLOCK0 returns to read mode and starts no erase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset to read mode |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_addr | input | 10 | Byte address of the write |
| wr_data | input | 8 | Write data or command byte |
| rd_addr | input | 10 | Byte address for the array read port |
| rd_data | output | 8 | Stored word, one cycle after rd_addr |
| rd_mode | output | 2 | Read source: 0 array, 1 ID, 2 status, 3 query |
| erase_start | output | 1 | One-cycle erase request to the status unit |
| erase_kind | output | 1 | 1 chip erase, 0 sector erase |
| erase_sector | output | 2 | Sector index of a sector erase |
| erase_done | input | 1 | One-cycle completion pulse from the status unit |

## Verification
The bench targets the ordering corners of the unlock protocol: a half-correct unlock pair, a command at the wrong address and an unknown opcode. A sequencer that kept partial progress would accept a command afterwards without a fresh unlock. It sends erase_done well before the fill ends. A design that exits on the first pulse would report array mode while a sector still holds old data. It sends 0xF0 as program data and again during a bypass erase. Wrongly honouring it would either skip the AND into the array or drop bypass, and the following unlocked program would then have no effect. Repeated programs of one word check that bits are only cleared, and erase checks that words outside the chosen sector keep their contents.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    typedef enum logic [1:0] {
        MODE_ARRAY  = 2'd0,
        MODE_ID     = 2'd1,
        MODE_STATUS = 2'd2,
        MODE_QUERY  = 2'd3
    } rd_mode_e;

    typedef enum logic [3:0] {
        ST_READ,
        ST_UNLK2,
        ST_CMD,
        ST_PROG,
        ST_AUTOSEL,
        ST_QUERY,
        ST_ER_UNLK1,
        ST_ER_UNLK2,
        ST_ER_CMD,
        ST_ERASING
    } seq_state_e;

    typedef enum logic {
        ER_SECTOR = 1'b0,
        ER_CHIP   = 1'b1
    } erase_kind_e;

    localparam logic [7:0] OP_RESET    = 8'hF0;
    localparam logic [7:0] OP_KEY_A    = 8'hAA;
    localparam logic [7:0] OP_KEY_B    = 8'h55;
    localparam logic [7:0] OP_BYPASS   = 8'h20;
    localparam logic [7:0] OP_ER_SETUP = 8'h80;
    localparam logic [7:0] OP_IDENT    = 8'h90;
    localparam logic [7:0] OP_PROGRAM  = 8'hA0;
    localparam logic [7:0] OP_CHIP_ER  = 8'h10;
    localparam logic [7:0] OP_SECT_ER  = 8'h30;
    localparam logic [7:0] OP_QUERY    = 8'h98;
    localparam int         QUERY_WOFF  = 'h55;

    function automatic int width_shift(input int bytes);
        return (bytes >= 4) ? 2 : ((bytes == 2) ? 1 : 0);
    endfunction

    function automatic rd_mode_e mode_of(input seq_state_e s);
        case (s)
            ST_PROG, ST_ERASING: return MODE_STATUS;
            ST_AUTOSEL:          return MODE_ID;
            ST_QUERY:            return MODE_QUERY;
            default:             return MODE_ARRAY;
        endcase
    endfunction

endpackage

// File: rtl/fcs_addr_map.sv
module fcs_addr_map #(
    parameter int SECTOR_BYTES = 256,
    parameter int NUM_SECTORS  = 4,
    parameter int WIDTH_BYTES  = 1,
    localparam int AW  = $clog2(SECTOR_BYTES * NUM_SECTORS),
    localparam int WS  = fcs_pkg::width_shift(WIDTH_BYTES),
    localparam int SOB = $clog2(SECTOR_BYTES),
    localparam int OW  = SOB - WS,
    localparam int IW  = AW - WS,
    localparam int SW  = AW - SOB
) (
    input  logic [AW-1:0] byte_addr,
    output logic [IW-1:0] word_idx,
    output logic [OW-1:0] word_off,
    output logic [SW-1:0] sector
);
    // word index across the chip, word offset inside a sector, sector number
    assign word_idx = byte_addr[AW-1:WS];
    assign word_off = byte_addr[SOB-1:WS];
    assign sector   = byte_addr[AW-1:SOB];
endmodule

// File: rtl/fcs_decoder.sv
module fcs_decoder
    import fcs_pkg::*;
#(
    parameter int OW      = 8,
    parameter int SW      = 2,
    parameter int UNLOCK0 = 'h55,
    parameter int UNLOCK1 = 'h2A
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [7:0]    op,
    input  logic [OW-1:0] woff,
    input  logic [SW-1:0] wsec,
    input  logic          sweep_fin,
    input  logic          erase_done,
    output logic          prog_we,
    output logic          erase_start,
    output erase_kind_e   erase_kind,
    output logic [SW-1:0] erase_sector,
    output rd_mode_e      rd_mode
);
    localparam logic [OW-1:0] U0 = OW'(UNLOCK0);
    localparam logic [OW-1:0] U1 = OW'(UNLOCK1);
    localparam logic [OW-1:0] QO = OW'(QUERY_WOFF);

    seq_state_e state, nxt;
    logic bypass, nbyp;
    logic go, go_chip;
    logic fin_seen, done_seen;
    logic erase_over;

    assign erase_over = (fin_seen || sweep_fin) && (done_seen || erase_done);
    assign prog_we    = wr_en && (state == ST_PROG);
    assign rd_mode    = mode_of(state);

    always_comb begin
        nxt     = state;
        nbyp    = bypass;
        go      = 1'b0;
        go_chip = 1'b0;
        if (state == ST_ERASING) begin
            if (erase_over) nxt = bypass ? ST_CMD : ST_READ;
        end else if (wr_en) begin
            if (state == ST_PROG) begin
                nxt = bypass ? ST_CMD : ST_READ;
            end else if (op == OP_RESET) begin
                nxt  = ST_READ;
                nbyp = 1'b0;
            end else begin
                nxt  = ST_READ;
                nbyp = 1'b0;
                case (state)
                    ST_READ: begin
                        if (op == OP_QUERY && woff == QO)     nxt = ST_QUERY;
                        else if (op == OP_KEY_A && woff == U0) nxt = ST_UNLK2;
                    end
                    ST_UNLK2: begin
                        if (op == OP_KEY_B && woff == U1) nxt = ST_CMD;
                    end
                    ST_CMD: begin
                        if (bypass || woff == U0) begin
                            case (op)
                                OP_BYPASS:   begin nxt = ST_CMD;      nbyp = 1'b1;   end
                                OP_ER_SETUP: begin nxt = ST_ER_UNLK1; nbyp = bypass; end
                                OP_IDENT:    begin nxt = ST_AUTOSEL;  nbyp = bypass; end
                                OP_PROGRAM:  begin nxt = ST_PROG;     nbyp = bypass; end
                                default:     ;
                            endcase
                        end
                    end
                    ST_AUTOSEL: begin
                        if (op == OP_QUERY && woff == QO) begin
                            nxt  = ST_QUERY;
                            nbyp = bypass;
                        end
                    end
                    ST_ER_UNLK1: begin
                        if (op == OP_KEY_A && woff == U0) begin
                            nxt  = ST_ER_UNLK2;
                            nbyp = bypass;
                        end
                    end
                    ST_ER_UNLK2: begin
                        if (op == OP_KEY_B && woff == U1) begin
                            nxt  = ST_ER_CMD;
                            nbyp = bypass;
                        end
                    end
                    ST_ER_CMD: begin
                        if (op == OP_CHIP_ER && woff == U0) begin
                            nxt = ST_ERASING; nbyp = bypass; go = 1'b1; go_chip = 1'b1;
                        end else if (op == OP_SECT_ER) begin
                            nxt = ST_ERASING; nbyp = bypass; go = 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_READ;
            bypass       <= 1'b0;
            fin_seen     <= 1'b0;
            done_seen    <= 1'b0;
            erase_start  <= 1'b0;
            erase_kind   <= ER_SECTOR;
            erase_sector <= '0;
        end else begin
            state       <= nxt;
            bypass      <= nbyp;
            erase_start <= go;
            if (go) begin
                erase_kind   <= go_chip ? ER_CHIP : ER_SECTOR;
                erase_sector <= wsec;
                fin_seen     <= 1'b0;
                done_seen    <= 1'b0;
            end else if (state == ST_ERASING) begin
                if (sweep_fin)  fin_seen  <= 1'b1;
                if (erase_done) done_seen <= 1'b1;
            end
        end
    end

    // R6
    reset_op_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && op == OP_RESET && state != ST_PROG && state != ST_ERASING)
        |=> (!bypass && state == ST_READ));

    // R4
    query_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && state == ST_QUERY) |=> (state == ST_READ));

endmodule

// File: rtl/fcs_array.sv
module fcs_array
    import fcs_pkg::*;
#(
    parameter int DW  = 8,
    parameter int NW  = 1024,
    parameter int WPS = 256,
    parameter int SW  = 2,
    localparam int IW  = $clog2(NW),
    localparam int WOB = $clog2(WPS),
    localparam int CW  = $clog2(NW + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          prog_we,
    input  logic [IW-1:0] prog_idx,
    input  logic [DW-1:0] prog_data,
    input  logic          erase_start,
    input  erase_kind_e   erase_kind,
    input  logic [SW-1:0] erase_sector,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data,
    output logic          sweep_busy,
    output logic          sweep_fin
);
    logic [DW-1:0] mem [NW];
    logic [IW-1:0] sweep_ptr;
    logic [CW-1:0] sweep_left;
    logic [DW-1:0] old_word;

    assign old_word = mem[prog_idx];

    always_ff @(posedge clk) begin
        if (sweep_busy)   mem[sweep_ptr] <= '1;
        else if (prog_we) mem[prog_idx]  <= old_word & prog_data;
        rd_data <= mem[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sweep_busy <= 1'b0;
            sweep_fin  <= 1'b0;
            sweep_ptr  <= '0;
            sweep_left <= '0;
        end else begin
            sweep_fin <= 1'b0;
            if (erase_start) begin
                sweep_busy <= 1'b1;
                if (erase_kind == ER_CHIP) begin
                    sweep_ptr  <= '0;
                    sweep_left <= CW'(NW);
                end else begin
                    sweep_ptr  <= {erase_sector, {WOB{1'b0}}};
                    sweep_left <= CW'(WPS);
                end
            end else if (sweep_busy) begin
                sweep_ptr  <= sweep_ptr + 1'b1;
                sweep_left <= sweep_left - 1'b1;
                if (sweep_left == CW'(1)) begin
                    sweep_busy <= 1'b0;
                    sweep_fin  <= 1'b1;
                end
            end
        end
    end

    // R10
    no_prog_in_sweep_chk: assert property (@(posedge clk) disable iff (rst)
        !(prog_we && sweep_busy));

    // R5
    prog_clears_only_chk: assert property (@(posedge clk) disable iff (rst)
        prog_we |=> ((mem[$past(prog_idx)] & ~$past(old_word)) == '0));

    // R9
    fin_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        sweep_fin |-> (!sweep_busy && $past(sweep_busy)));

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import fcs_pkg::*;
#(
    parameter int SECTOR_BYTES = 256,
    parameter int NUM_SECTORS  = 4,
    parameter int WIDTH_BYTES  = 1,
    parameter int UNLOCK0      = 'h55,
    parameter int UNLOCK1      = 'h2A,
    localparam int DW  = 8 * WIDTH_BYTES,
    localparam int AW  = $clog2(SECTOR_BYTES * NUM_SECTORS),
    localparam int WS  = width_shift(WIDTH_BYTES),
    localparam int SOB = $clog2(SECTOR_BYTES),
    localparam int OW  = SOB - WS,
    localparam int IW  = AW - WS,
    localparam int SW  = AW - SOB,
    localparam int NW  = (SECTOR_BYTES * NUM_SECTORS) >> WS,
    localparam int WPS = SECTOR_BYTES >> WS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic [1:0]    rd_mode,
    output logic          erase_start,
    output logic          erase_kind,
    output logic [SW-1:0] erase_sector,
    input  logic          erase_done
);
    logic [IW-1:0] w_idx;
    logic [OW-1:0] w_off;
    logic [SW-1:0] w_sec;
    logic          prog_we;
    logic          sweep_busy, sweep_fin;
    erase_kind_e   kind_q;
    rd_mode_e      mode_q;

    fcs_addr_map #(
        .SECTOR_BYTES(SECTOR_BYTES),
        .NUM_SECTORS (NUM_SECTORS),
        .WIDTH_BYTES (WIDTH_BYTES)
    ) u_wmap (
        .byte_addr(wr_addr),
        .word_idx (w_idx),
        .word_off (w_off),
        .sector   (w_sec)
    );

    fcs_decoder #(
        .OW     (OW),
        .SW     (SW),
        .UNLOCK0(UNLOCK0),
        .UNLOCK1(UNLOCK1)
    ) u_dec (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .op          (wr_data[7:0]),
        .woff        (w_off),
        .wsec        (w_sec),
        .sweep_fin   (sweep_fin),
        .erase_done  (erase_done),
        .prog_we     (prog_we),
        .erase_start (erase_start),
        .erase_kind  (kind_q),
        .erase_sector(erase_sector),
        .rd_mode     (mode_q)
    );

    fcs_array #(
        .DW (DW),
        .NW (NW),
        .WPS(WPS),
        .SW (SW)
    ) u_arr (
        .clk         (clk),
        .rst         (rst),
        .prog_we     (prog_we),
        .prog_idx    (w_idx),
        .prog_data   (wr_data),
        .erase_start (erase_start),
        .erase_kind  (kind_q),
        .erase_sector(erase_sector),
        .rd_idx      (rd_addr[AW-1:WS]),
        .rd_data     (rd_data),
        .sweep_busy  (sweep_busy),
        .sweep_fin   (sweep_fin)
    );

    assign erase_kind = kind_q;
    assign rd_mode    = mode_q;

    // R8
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        erase_start |=> !erase_start);

    // R8
    status_on_start_chk: assert property (@(posedge clk) disable iff (rst)
        erase_start |-> (rd_mode == 2'd2));

endmodule

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [9:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [9:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [1:0] rd_mode;
    logic       erase_start;
    logic       erase_kind;
    logic [1:0] erase_sector;
    logic       erase_done = 1'b0;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    flash_cmd_seq u_flash_cmd_seq (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .rd_mode(rd_mode),
        .erase_start(erase_start), .erase_kind(erase_kind),
        .erase_sector(erase_sector), .erase_done(erase_done)
    );

    // entry: {byte address, data, expected mode, requirement number}
    localparam int NV = 24;
    localparam logic [23:0] VEC [NV] = '{
        {10'h055, 8'hAA, 2'd0, 4'd2},   // R2 first key
        {10'h02A, 8'h55, 2'd0, 4'd2},   // R2 second key
        {10'h055, 8'h90, 2'd1, 4'd3},   // R3 ID mode
        {10'h055, 8'h98, 2'd3, 4'd3},   // R3 ID -> query
        {10'h000, 8'h12, 2'd0, 4'd4},   // R4 write leaves query
        {10'h055, 8'h98, 2'd3, 4'd4},   // R4 direct query entry
        {10'h010, 8'hF0, 2'd0, 4'd6},   // R6 reset op
        {10'h055, 8'hAA, 2'd0, 4'd2},
        {10'h02B, 8'h55, 2'd0, 4'd2},   // R2 wrong second address
        {10'h055, 8'h90, 2'd0, 4'd2},   // R2 no command without unlock
        {10'h055, 8'hAA, 2'd0, 4'd2},
        {10'h02A, 8'h55, 2'd0, 4'd2},
        {10'h054, 8'h90, 2'd0, 4'd2},   // R2 command at wrong address
        {10'h255, 8'hAA, 2'd0, 4'd11},  // R11 unlock in sector 2
        {10'h22A, 8'h55, 2'd0, 4'd11},
        {10'h355, 8'h90, 2'd1, 4'd11},  // R11 command in sector 3
        {10'h000, 8'hF0, 2'd0, 4'd6},
        {10'h055, 8'hAA, 2'd0, 4'd2},
        {10'h02A, 8'h55, 2'd0, 4'd2},
        {10'h055, 8'h77, 2'd0, 4'd2},   // R2 unknown opcode
        {10'h055, 8'hAA, 2'd0, 4'd6},
        {10'h02A, 8'h55, 2'd0, 4'd6},
        {10'h055, 8'hF0, 2'd0, 4'd6},   // R6 reset at command cycle
        {10'h055, 8'h90, 2'd0, 4'd6}    // R6 proves read mode
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_addr = a;
        @(negedge clk);
        d = rd_data;
    endtask

    task automatic unlock();
        wr(10'h055, 8'hAA);
        wr(10'h02A, 8'h55);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_done();
        @(negedge clk);
        erase_done = 1'b1;
        @(negedge clk);
        erase_done = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R9 watchdog act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 mode", rd_mode, 2'd0);
        check("R1 start", erase_start, 1'b0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][23:14], VEC[i][13:6]);
            check($sformatf("R%0d vec%0d", VEC[i][3:0], i), rd_mode, VEC[i][5:4]);
        end

        // R8 chip erase, R9 done after fill
        unlock();
        wr(10'h055, 8'h80);
        unlock();
        wr(10'h055, 8'h10);
        check("R8 start", erase_start, 1'b1);
        check("R8 kind chip", erase_kind, 1'b1);
        check("R8 status mode", rd_mode, 2'd2);
        idle(1100);
        check("R9 waits for done", rd_mode, 2'd2);
        pulse_done();
        check("R9 exit to read", rd_mode, 2'd0);
        rd(10'h000, d); check("R8 chip word0", d, 8'hFF);
        rd(10'h3FF, d); check("R8 chip last", d, 8'hFF);
        // R1 read latency: rd_data follows one clock after address
        check("R1 read port", rd_data, 8'hFF);

        // R5 program ANDs, only clears
        unlock();
        wr(10'h055, 8'hA0);
        check("R5 status mode", rd_mode, 2'd2);
        wr(10'h100, 8'h3C);
        check("R5 back to read", rd_mode, 2'd0);
        rd(10'h100, d); check("R5 program", d, 8'h3C);
        unlock(); wr(10'h055, 8'hA0);
        wr(10'h100, 8'hF0);   // R6 0xF0 taken as data
        check("R6 data F0 mode", rd_mode, 2'd0);
        rd(10'h100, d); check("R6 F0 programmed", d, 8'h30);
        unlock(); wr(10'h055, 8'hA0);
        wr(10'h100, 8'hFF);
        rd(10'h100, d); check("R5 bits never set", d, 8'h30);
        unlock(); wr(10'h055, 8'hA0);
        wr(10'h101, 8'h0F);
        rd(10'h101, d); check("R5 second word", d, 8'h0F);

        // R7 bypass
        unlock();
        wr(10'h055, 8'h20);
        check("R7 bypass mode", rd_mode, 2'd0);
        wr(10'h000, 8'hA0);
        check("R7 no unlock needed", rd_mode, 2'd2);
        wr(10'h200, 8'h5A);
        check("R7 returns to command", rd_mode, 2'd0);
        rd(10'h200, d); check("R7 program", d, 8'h5A);
        wr(10'h123, 8'hA0);
        wr(10'h201, 8'h00);
        rd(10'h201, d); check("R7 second program", d, 8'h00);
        wr(10'h000, 8'hF0);
        wr(10'h000, 8'hA0);
        check("R6 bypass cleared", rd_mode, 2'd0);
        wr(10'h202, 8'h00);
        rd(10'h202, d); check("R6 no program after exit", d, 8'hFF);

        // R3 bypass exit from ID mode
        unlock();
        wr(10'h055, 8'h20);
        wr(10'h077, 8'h90);
        check("R3 ID in bypass", rd_mode, 2'd1);
        wr(10'h000, 8'h00);
        check("R3 exit", rd_mode, 2'd0);
        wr(10'h000, 8'hA0);
        check("R3 bypass gone", rd_mode, 2'd0);

        // R8 sector erase in bypass, R9 early done, R10 ignored writes
        unlock();
        wr(10'h055, 8'h20);
        wr(10'h000, 8'h80);
        unlock();
        wr(10'h1A0, 8'h30);
        check("R8 start sector", erase_start, 1'b1);
        check("R8 kind sector", erase_kind, 1'b0);
        check("R8 sector index", erase_sector, 2'd1);
        pulse_done();
        wr(10'h000, 8'hF0);   // R10
        wr(10'h000, 8'hA0);
        wr(10'h100, 8'h00);
        idle(100);
        check("R9 early done holds busy", rd_mode, 2'd2);
        idle(200);
        check("R9 exit to command", rd_mode, 2'd0);
        rd(10'h100, d); check("R8 sector erased", d, 8'hFF);
        rd(10'h101, d); check("R8 sector erased 2", d, 8'hFF);
        rd(10'h200, d); check("R8 other sector kept", d, 8'h5A);
        wr(10'h000, 8'hA0);
        check("R10 bypass survived F0", rd_mode, 2'd2);
        wr(10'h1FF, 8'h81);
        rd(10'h1FF, d); check("R10 program after erase", d, 8'h81);
        wr(10'h000, 8'hF0);

        // R12 chip erase at wrong address
        unlock();
        wr(10'h055, 8'h80);
        unlock();
        wr(10'h056, 8'h10);
        check("R12 no start", erase_start, 1'b0);
        check("R12 read mode", rd_mode, 2'd0);
        rd(10'h200, d); check("R12 data kept", d, 8'h5A);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule